// File: doc/BRIEF.md
# Cache Synchronize Writeback Sequencer

This block runs a synchronize pass over the tag array of a write-back second-level cache. It takes an asynchronous, active-low request and brings it into the clock domain. A request is accepted only once it has stayed low for two clocks. After acceptance the block stops the processor from starting new bus cycles and waits until the surrounding logic reports that no processor-side or memory-side cycle is still outstanding. At that point the block counts the request as recognized and pulls its active-low busy output low.

The sequencer then visits the 16 tag entries in ascending index order. Shared, exclusive and invalid lines are left as they are. For a modified line the block first asks the upstream processor through an inquire handshake whether it holds newer data. It then requests a memory writeback, flagging when the processor's data has to be merged into the writeback buffer. Finally it rewrites the tag as exclusive, so nothing is ever invalidated. At every line boundary a memory-side snoop may use the tag port, and the walk resumes at the same index afterwards. A flush or reset stops the pass at once.

Top module: `cache_sync_sequencer`

## Requirements
- R1: A request is recognized only after `sync_req_n` has been sampled low on at least two consecutive clocks. A low pulse that is seen on a single clock starts nothing.
- R2: `ads_block` is high from the moment a request is accepted, through the drain wait, until the pass ends or is aborted. It is high whenever `sync_busy_n` is low.
- R3: `sync_busy_n` stays high while `cycles_idle` is low. It falls on the clock edge that samples `cycles_idle` high during the drain wait.
- R4: Tag states are encoded as 00 invalid, 01 shared, 10 exclusive and 11 modified. Entries are visited in ascending order. Each modified entry produces exactly one inquire followed by exactly one writeback, and both carry that entry's index.
- R5: `wb_merge` carries the value of `inq_hit_mod` that the processor returned on the inquire for the same line.
- R6: After a full pass, every entry that was modified (11) reads exclusive (10), and every other entry keeps its state.
- R7: `sync_busy_n` rises and `ads_block` falls on the same edge once the last entry has been processed.
- R8: A request that is accepted, or still held, while a pass is pending or running is ignored and starts no further pass.
- R9: A flush pulse during a pass returns `sync_busy_n` high and `ads_block` low on the next edge. No further inquire or writeback follows, and entries that were not yet visited keep their states.
- R10: Reset during a pass ends it the same way and issues no further inquire or writeback.
- R11: A snoop is granted while the block is idle, while it waits for the drain, and at each line boundary of the walk. Its read returns the stored state one clock later. A snoop write to an entry the walk has not yet reached is seen by the walk.
- R12: `inq_req` and `wb_req` are never high together, and each stays high until its acknowledge is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also aborts a pass |
| flush | input | 1 | Flush request; aborts a pass |
| sync_req_n | input | 1 | Asynchronous active-low synchronize request |
| cycles_idle | input | 1 | High when no processor or memory cycle is outstanding |
| ads_block | output | 1 | Blocks new processor address strobes |
| sync_busy_n | output | 1 | Active-low: pass recognized and in progress |
| inq_req | output | 1 | Inquire request to the processor |
| inq_idx | output | 4 | Entry index of the inquire |
| inq_ack | input | 1 | Inquire done |
| inq_hit_mod | input | 1 | Processor held newer modified data (valid with `inq_ack`) |
| wb_req | output | 1 | Memory writeback request |
| wb_idx | output | 4 | Entry index of the writeback |
| wb_merge | output | 1 | Processor data must be merged into the writeback buffer |
| wb_ack | input | 1 | Writeback accepted |
| snp_req | input | 1 | Snoop access request to the tag array |
| snp_we | input | 1 | Snoop access is a write |
| snp_idx | input | 4 | Snoop entry index |
| snp_wstate | input | 2 | State written by a snoop |
| snp_gnt | output | 1 | Snoop takes the tag port on this clock |
| snp_rstate | output | 2 | State read by the last granted snoop |

## Verification
Several properties are checked on every cycle: the two handshakes never overlap and each request is held until its acknowledge, a busy output always comes with blocked address strobes, busy only falls after the idle input was seen, a writeback always follows an acknowledged inquire, snoop grants never fall inside a line's handshakes, and a flush always leaves the block idle on the next edge. Only the directed scenarios can show the things that depend on history or data. These are the exact ascending list of written-back indices, the merge flags, the final tag contents, the rejection of a one-clock request, the rejection of requests during a pass, a snoop write being picked up by the walk, and which entries an abort leaves untouched.

// File: rtl/cache_sync_pkg.sv
package cache_sync_pkg;

  typedef enum logic [1:0] {
    ST_INV = 2'b00,
    ST_SHR = 2'b01,
    ST_EXC = 2'b10,
    ST_MOD = 2'b11
  } line_state_e;

  typedef enum logic [2:0] {
    W_IDLE,
    W_DRAIN,
    W_READ,
    W_CHECK,
    W_INQ,
    W_WB,
    W_UPD
  } walk_state_e;

endpackage

// File: rtl/sync_req_qual.sv
module sync_req_qual #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_n_async,
  output logic start_pulse
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   hold_q;
  logic                   seen_q;
  logic                   both_low;

  // two consecutive synchronized samples of the asserted level
  assign both_low = sync_q[SYNC_STAGES-1] & hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q      <= '0;
      hold_q      <= 1'b0;
      seen_q      <= 1'b0;
      start_pulse <= 1'b0;
    end else begin
      sync_q      <= {sync_q[SYNC_STAGES-2:0], ~req_n_async};
      hold_q      <= sync_q[SYNC_STAGES-1];
      seen_q      <= both_low;
      start_pulse <= both_low & ~seen_q;
    end
  end

endmodule

// File: rtl/sync_tag_ram.sv
module sync_tag_ram #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 2,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             en,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      rdata <= mem[addr];
    end
  end

endmodule

// File: rtl/sync_walk_ctrl.sv
module sync_walk_ctrl
  import cache_sync_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          start,
  input  logic          cycles_idle,
  output logic          ads_block,
  output logic          busy_n,
  output logic          inq_req,
  input  logic          inq_ack,
  input  logic          inq_hit_mod,
  output logic          wb_req,
  output logic          wb_merge,
  input  logic          wb_ack,
  output logic [IW-1:0] idx,
  input  logic          snp_req,
  input  logic          snp_we,
  input  logic [IW-1:0] snp_idx,
  input  logic [1:0]    snp_wstate,
  output logic          snp_gnt,
  output logic          ram_en,
  output logic          ram_we,
  output logic [IW-1:0] ram_addr,
  output logic [1:0]    ram_wdata,
  input  logic [1:0]    ram_rdata
);

  walk_state_e state_q;
  logic        last_line;
  logic        snoop_slot;

  assign last_line  = (idx == IW'(ENTRIES - 1));
  assign snoop_slot = (state_q == W_IDLE) || (state_q == W_DRAIN) || (state_q == W_READ);

  // tag port: a snoop wins at line boundaries, the walk holds its index
  assign snp_gnt   = snp_req && snoop_slot;
  assign ram_en    = snp_gnt || (state_q == W_READ) || (state_q == W_UPD);
  assign ram_we    = snp_gnt ? snp_we : (state_q == W_UPD);
  assign ram_addr  = snp_gnt ? snp_idx : idx;
  assign ram_wdata = snp_gnt ? snp_wstate : ST_EXC;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= W_IDLE;
      idx       <= '0;
      busy_n    <= 1'b1;
      ads_block <= 1'b0;
      inq_req   <= 1'b0;
      wb_req    <= 1'b0;
      wb_merge  <= 1'b0;
    end else if (flush) begin
      state_q   <= W_IDLE;
      busy_n    <= 1'b1;
      ads_block <= 1'b0;
      inq_req   <= 1'b0;
      wb_req    <= 1'b0;
    end else begin
      unique case (state_q)
        W_IDLE: if (start) begin
          state_q   <= W_DRAIN;
          ads_block <= 1'b1;
        end
        W_DRAIN: if (cycles_idle) begin
          state_q <= W_READ;
          busy_n  <= 1'b0;
          idx     <= '0;
        end
        W_READ: if (!snp_req) state_q <= W_CHECK;
        W_CHECK: begin
          if (ram_rdata == ST_MOD) begin
            state_q <= W_INQ;
            inq_req <= 1'b1;
          end else if (last_line) begin
            state_q   <= W_IDLE;
            busy_n    <= 1'b1;
            ads_block <= 1'b0;
          end else begin
            idx     <= idx + IW'(1);
            state_q <= W_READ;
          end
        end
        W_INQ: if (inq_ack) begin
          inq_req  <= 1'b0;
          wb_req   <= 1'b1;
          wb_merge <= inq_hit_mod;
          state_q  <= W_WB;
        end
        W_WB: if (wb_ack) begin
          wb_req  <= 1'b0;
          state_q <= W_UPD;
        end
        W_UPD: begin
          if (last_line) begin
            state_q   <= W_IDLE;
            busy_n    <= 1'b1;
            ads_block <= 1'b0;
          end else begin
            idx     <= idx + IW'(1);
            state_q <= W_READ;
          end
        end
        default: state_q <= W_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cache_sync_sequencer.sv
module cache_sync_sequencer #(
  parameter int ENTRIES     = 16,
  parameter int SYNC_STAGES = 2,
  localparam int IW         = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          sync_req_n,
  input  logic          cycles_idle,
  output logic          ads_block,
  output logic          sync_busy_n,
  output logic          inq_req,
  output logic [IW-1:0] inq_idx,
  input  logic          inq_ack,
  input  logic          inq_hit_mod,
  output logic          wb_req,
  output logic [IW-1:0] wb_idx,
  output logic          wb_merge,
  input  logic          wb_ack,
  input  logic          snp_req,
  input  logic          snp_we,
  input  logic [IW-1:0] snp_idx,
  input  logic [1:0]    snp_wstate,
  output logic          snp_gnt,
  output logic [1:0]    snp_rstate
);

  logic          start;
  logic          ram_en;
  logic          ram_we;
  logic [IW-1:0] ram_addr;
  logic [1:0]    ram_wdata;
  logic [1:0]    ram_rdata;
  logic [IW-1:0] walk_idx;

  sync_req_qual #(.SYNC_STAGES(SYNC_STAGES)) u_qual (
    .clk        (clk),
    .rst        (rst),
    .req_n_async(sync_req_n),
    .start_pulse(start)
  );

  sync_walk_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush),
    .start      (start),
    .cycles_idle(cycles_idle),
    .ads_block  (ads_block),
    .busy_n     (sync_busy_n),
    .inq_req    (inq_req),
    .inq_ack    (inq_ack),
    .inq_hit_mod(inq_hit_mod),
    .wb_req     (wb_req),
    .wb_merge   (wb_merge),
    .wb_ack     (wb_ack),
    .idx        (walk_idx),
    .snp_req    (snp_req),
    .snp_we     (snp_we),
    .snp_idx    (snp_idx),
    .snp_wstate (snp_wstate),
    .snp_gnt    (snp_gnt),
    .ram_en     (ram_en),
    .ram_we     (ram_we),
    .ram_addr   (ram_addr),
    .ram_wdata  (ram_wdata),
    .ram_rdata  (ram_rdata)
  );

  sync_tag_ram #(.DEPTH(ENTRIES), .WIDTH(2)) u_tags (
    .clk  (clk),
    .en   (ram_en),
    .we   (ram_we),
    .addr (ram_addr),
    .wdata(ram_wdata),
    .rdata(ram_rdata)
  );

  assign inq_idx    = walk_idx;
  assign wb_idx     = walk_idx;
  assign snp_rstate = ram_rdata;

endmodule

// File: rtl/sync_walk_checker.sv
module sync_walk_checker (
  input logic clk,
  input logic rst,
  input logic flush,
  input logic cycles_idle,
  input logic ads_block,
  input logic sync_busy_n,
  input logic inq_req,
  input logic inq_ack,
  input logic wb_req,
  input logic wb_ack,
  input logic snp_gnt
);

  p_busy_blocks_ads_r2: assert property (@(posedge clk) disable iff (rst)
    !sync_busy_n |-> ads_block);

  p_busy_after_drain_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(sync_busy_n) |-> $past(cycles_idle));

  p_handshake_busy_r4: assert property (@(posedge clk) disable iff (rst)
    (inq_req || wb_req) |-> !sync_busy_n);

  p_wb_after_inq_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(wb_req) |-> $past(inq_req && inq_ack));

  p_flush_abort_r9: assert property (@(posedge clk) disable iff (rst)
    flush |=> (sync_busy_n && !ads_block && !inq_req && !wb_req));

  p_snoop_boundary_r11: assert property (@(posedge clk) disable iff (rst)
    snp_gnt |-> (!inq_req && !wb_req));

  p_no_overlap_r12: assert property (@(posedge clk) disable iff (rst)
    !(inq_req && wb_req));

  p_inq_hold_r12: assert property (@(posedge clk) disable iff (rst || flush)
    (inq_req && !inq_ack) |=> inq_req);

  p_wb_hold_r12: assert property (@(posedge clk) disable iff (rst || flush)
    (wb_req && !wb_ack) |=> wb_req);

endmodule

bind cache_sync_sequencer sync_walk_checker u_walk_chk (
  .clk        (clk),
  .rst        (rst),
  .flush      (flush),
  .cycles_idle(cycles_idle),
  .ads_block  (ads_block),
  .sync_busy_n(sync_busy_n),
  .inq_req    (inq_req),
  .inq_ack    (inq_ack),
  .wb_req     (wb_req),
  .wb_ack     (wb_ack),
  .snp_gnt    (snp_gnt)
);

// File: tb/test_cache_sync_sequencer.sv
`timescale 1ns/1ps
module test_cache_sync_sequencer;

  localparam int N  = 16;
  localparam int IW = 4;

  logic clk = 0;
  logic rst = 1, flush = 0, sync_req_n = 1, cycles_idle = 1;
  logic ads_block, sync_busy_n, inq_req, wb_req, wb_merge, snp_gnt;
  logic [IW-1:0] inq_idx, wb_idx;
  logic inq_ack = 0, inq_hit_mod = 0, wb_ack = 0;
  logic snp_req = 0, snp_we = 0;
  logic [IW-1:0] snp_idx = '0;
  logic [1:0] snp_wstate = '0;
  logic [1:0] snp_rstate;

  int checks = 0, fails = 0;
  int wb_count = 0;
  int wb_log [64];
  int last_inq = -1;
  logic [N-1:0] cpu_dirty = '0;

  always #10 clk = ~clk;

  cache_sync_sequencer i_cache_sync_sequencer (
    .clk(clk), .rst(rst), .flush(flush), .sync_req_n(sync_req_n),
    .cycles_idle(cycles_idle), .ads_block(ads_block), .sync_busy_n(sync_busy_n),
    .inq_req(inq_req), .inq_idx(inq_idx), .inq_ack(inq_ack), .inq_hit_mod(inq_hit_mod),
    .wb_req(wb_req), .wb_idx(wb_idx), .wb_merge(wb_merge), .wb_ack(wb_ack),
    .snp_req(snp_req), .snp_we(snp_we), .snp_idx(snp_idx), .snp_wstate(snp_wstate),
    .snp_gnt(snp_gnt), .snp_rstate(snp_rstate)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // processor / memory responder: one-cycle acknowledges
  initial begin
    forever begin
      @(negedge clk);
      inq_ack = 0;
      wb_ack  = 0;
      if (inq_req) begin
        last_inq    = int'(inq_idx);
        inq_hit_mod = cpu_dirty[inq_idx];
        inq_ack     = 1;
      end
      if (wb_req) begin
        check(int'(wb_idx) == last_inq, "R4", "writeback index vs inquire", int'(wb_idx), last_inq);
        check(wb_merge == cpu_dirty[wb_idx], "R5", "merge flag", int'(wb_merge), int'(cpu_dirty[wb_idx]));
        if (wb_count < 64) wb_log[wb_count] = int'(wb_idx);
        wb_count++;
        wb_ack = 1;
      end
    end
  end

  task automatic snoop(input bit we, input int idx, input logic [1:0] ws,
                       output logic [1:0] rs);
    @(negedge clk);
    snp_req = 1; snp_we = we; snp_idx = IW'(idx); snp_wstate = ws;
    #1;
    while (!snp_gnt) begin @(negedge clk); #1; end
    @(negedge clk);
    snp_req = 0; snp_we = 0;
    rs = snp_rstate;
  endtask

  task automatic wait_busy(input logic lvl, input int limit, output bit ok);
    ok = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (sync_busy_n == lvl) begin ok = 1; break; end
    end
  endtask

  function automatic logic [1:0] init_state(input int i);
    return 2'((3 * i + 1) % 4);
  endfunction

  task automatic preload_all(input logic [1:0] st);
    logic [1:0] d;
    for (int i = 0; i < N; i++) snoop(1, i, st, d);
  endtask

  task automatic test_reset_state;
    check(ads_block == 0, "R2", "ads_block after reset", int'(ads_block), 0);
    check(sync_busy_n == 1, "R3", "busy_n after reset", int'(sync_busy_n), 1);
    check(!inq_req && !wb_req, "R12", "handshakes idle after reset", int'(inq_req | wb_req), 0);
  endtask

  task automatic test_qualify_and_drain;
    bit ok;
    preload_all(2'b00);
    cycles_idle = 0;
    @(negedge clk); sync_req_n = 0;
    @(negedge clk); sync_req_n = 1;
    cycles(8);
    check(ads_block == 0, "R1", "one-clock request ignored", int'(ads_block), 0);
    sync_req_n = 0;
    cycles(2);
    sync_req_n = 1;
    cycles(6);
    check(ads_block == 1, "R1", "two-clock request accepted", int'(ads_block), 1);
    check(sync_busy_n == 1, "R3", "busy_n held during drain", int'(sync_busy_n), 1);
    cycles(5);
    check(ads_block == 1, "R2", "ads_block during drain", int'(ads_block), 1);
    check(sync_busy_n == 1, "R3", "busy_n still high while cycles pending", int'(sync_busy_n), 1);
    cycles_idle = 1;
    @(negedge clk);
    check(sync_busy_n == 0, "R3", "busy_n falls when drained", int'(sync_busy_n), 0);
    wait_busy(1, 200, ok);
    check(ok, "R7", "all-invalid pass completes", int'(ok), 1);
    check(ads_block == 0, "R7", "ads_block drops with busy_n", int'(ads_block), 0);
    check(wb_count == 0, "R6", "no writeback for invalid lines", wb_count, 0);
  endtask

  task automatic test_full_walk;
    bit ok;
    logic [1:0] rs;
    int exp_wb [5] = '{2, 6, 10, 14, 15};
    for (int i = 0; i < N; i++) snoop(1, i, init_state(i), rs);
    wb_count = 0;
    cpu_dirty = 16'h0440;
    @(negedge clk); sync_req_n = 0;
    wait_busy(0, 50, ok);
    check(ok, "R3", "pass recognized", int'(ok), 1);
    check(ads_block == 1, "R2", "ads_block while busy", int'(ads_block), 1);
    snoop(1, 15, 2'b11, rs);
    snoop(0, 3, 2'b00, rs);
    check(rs == 2'b10, "R11", "snoop read mid-walk", int'(rs), 2);
    @(negedge clk); sync_req_n = 1;
    cycles(3);
    sync_req_n = 0;
    wait_busy(1, 500, ok);
    check(ok, "R7", "walk completes", int'(ok), 1);
    check(ads_block == 0, "R7", "ads_block drops at completion", int'(ads_block), 0);
    check(wb_count == 5, "R4", "writeback count", wb_count, 5);
    for (int k = 0; k < 5; k++)
      if (k < wb_count)
        check(wb_log[k] == exp_wb[k], "R4", "writeback order", wb_log[k], exp_wb[k]);
    check(wb_count == 5 && wb_log[4] == 15, "R11", "snooped-in modified line written back",
          wb_log[4], 15);
    cycles(12);
    check(ads_block == 0 && sync_busy_n == 1, "R8", "held request does not restart",
          int'(ads_block), 0);
    check(wb_count == 5, "R8", "no extra writebacks", wb_count, 5);
    sync_req_n = 1;
    for (int i = 0; i < N; i++) begin
      logic [1:0] e;
      e = (i == 15) ? 2'b10 : (init_state(i) == 2'b11 ? 2'b10 : init_state(i));
      snoop(0, i, 2'b00, rs);
      check(rs == e, "R6", $sformatf("final state of entry %0d", i), int'(rs), int'(e));
    end
  endtask

  task automatic test_flush_abort;
    bit ok;
    logic [1:0] rs;
    int base;
    preload_all(2'b11);
    cpu_dirty = '0;
    wb_count = 0;
    @(negedge clk); sync_req_n = 0;
    wait_busy(0, 50, ok);
    check(ok, "R9", "pass started before flush", int'(ok), 1);
    for (int i = 0; i < 400 && wb_count < 3; i++) @(negedge clk);
    #1 flush = 1;
    @(negedge clk); #1 flush = 0;
    check(sync_busy_n == 1, "R9", "busy_n after flush", int'(sync_busy_n), 1);
    check(ads_block == 0, "R9", "ads_block after flush", int'(ads_block), 0);
    base = wb_count;
    cycles(15);
    check(wb_count == base && !inq_req && !wb_req, "R9", "no handshake after flush",
          wb_count, base);
    sync_req_n = 1;
    for (int i = 0; i < N; i++) begin
      logic [1:0] e;
      e = (i < 2) ? 2'b10 : 2'b11;
      snoop(0, i, 2'b00, rs);
      check(rs == e, "R9", $sformatf("state of entry %0d after flush", i), int'(rs), int'(e));
    end
  endtask

  task automatic test_reset_abort;
    bit ok;
    logic [1:0] rs;
    int base;
    wb_count = 0;
    @(negedge clk); sync_req_n = 0;
    wait_busy(0, 50, ok);
    check(ok, "R10", "pass started before reset", int'(ok), 1);
    for (int i = 0; i < 400 && wb_count < 2; i++) @(negedge clk);
    #1 rst = 1;
    @(negedge clk);
    check(sync_busy_n == 1 && ads_block == 0, "R10", "idle during reset",
          int'(sync_busy_n), 1);
    #1 rst = 0;
    sync_req_n = 1;
    base = wb_count;
    cycles(15);
    check(wb_count == base && sync_busy_n == 1, "R10", "no handshake after reset",
          wb_count, base);
    snoop(0, 15, 2'b00, rs);
    check(rs == 2'b11, "R10", "unvisited entry keeps state", int'(rs), 3);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    cycles(3);
    #1 rst = 0;
    @(negedge clk);
    test_reset_state();
    test_qualify_and_drain();
    test_full_walk();
    test_flush_abort();
    test_reset_abort();
    cycles(2);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule